// File: doc/BRIEF.md
# Serial NOR Flash Write Sequencer

This block sits on the host side of a four-wire SPI link to a serial NOR flash and turns one-line local requests into complete write command sequences. A request selects one of four jobs: program a run of bytes from a host buffer, erase one sector, erase the whole device, or load a new value into the flash status register. The block sends a write-enable frame before each write command. It then sends the command frame with its opcode, 24-bit address and payload. It then polls the flash status register until the busy flag drops and raises a one-cycle completion pulse.

Program requests may be longer than one flash page and may start anywhere inside a page. The sequencer cuts the buffer at every 256-byte page boundary. Each piece gets its own write-enable, program frame and polling loop, so the host never has to split a buffer. The host presents the buffer through an index/data pair: the block drives the index of the byte it needs and expects the matching byte combinationally on the data input. If the busy flag is still set after a bounded number of status reads, the job is abandoned and the completion pulse carries an error flag.

Top module: `flash_wr_sequencer`

## Requirements
- R1: Every program, sector erase, bulk erase and status write frame is immediately preceded by a separate frame that carries only the write-enable opcode 06h.
- R2: A program frame carries opcode 02h, three address bytes (bits 23:16 first), then data bytes, where data byte k of the request is fetched by driving `bufIdx` = k.
- R3: A program frame never carries more bytes than remain in its 256-byte page. A request that crosses a page boundary is split into several write-enable, program and poll sequences. Together these write exactly `reqLen` bytes at consecutive addresses.
- R4: A sector erase frame is D8h plus three address bytes, a bulk erase frame is the single byte C7h, and a status write frame is 01h plus the `reqStatus` byte. `reqKind` codes are 0 program, 1 sector erase, 2 bulk erase, 3 status write.
- R5: After the write command, the block sends status read frames (opcode 05h followed by one read byte, whose last received bit is the busy flag). It repeats them until a read returns the flag clear, and only then reports done.
- R6: If `MAX_POLLS` consecutive status reads all return the busy flag set, the block sends no further reads and ends the job with `done` and `err` both high. If the flag clears on read number `MAX_POLLS`, the job ends without error.
- R7: `done` is a single-cycle pulse, `err` is high only together with `done`, and `reqReady` is high only while idle. A request offered while `reqReady` is low is ignored.
- R8: The bus runs in SPI mode 0. `sck` idles low and toggles only while `csN` is low. `mosi` never changes while `sck` is high, and bytes are sent most significant bit first.
- R9: Between two frames `csN` stays high for at least `GAP_CLKS` clock cycles, and it stays low without a break for the whole of a frame.
- R10: A program request with `reqLen` = 0 completes with `done` high, `err` low and no bus activity.
- R11: After reset `csN` is high, `sck` is low, `done` is low and `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken when `reqReady` is high |
| reqKind | input | 2 | Job code: 0 program, 1 sector erase, 2 bulk erase, 3 status write |
| reqAddr | input | 24 | Flash byte address for program and sector erase |
| reqLen | input | LEN_W | Number of bytes to program |
| reqStatus | input | 8 | Value for a status write |
| reqReady | output | 1 | Idle, a request will be accepted |
| bufIdx | output | LEN_W | Index of the buffer byte currently needed |
| bufData | input | 8 | Buffer byte at `bufIdx`, combinational from the host |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Poll timeout, valid with `done` |
| sck | output | 1 | SPI clock, mode 0 |
| csN | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to flash |
| miso | input | 1 | SPI data from flash |

## Verification
The bound checker watches the bus discipline on every cycle. It checks that the clock toggles only inside a frame, that output data holds while the clock is high, and that the chip-select high time meets the minimum gap. It also checks the one-cycle completion pulse, the pairing of the error flag with it, and that the block is never ready while a frame is open. Command content can only be shown by the bench's scenarios, which run a behavioural flash against the bus and inspect the frames it logs and its memory. These scenarios cover the write-enable prefix, the opcodes and addresses, the splitting at page boundaries, and the exact poll count at the timeout boundary. They also cover the zero-length request and the dropping of requests offered while busy.

// File: rtl/fws_pkg.sv
package fws_pkg;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'hD8;
  localparam logic [7:0] OP_BE   = 8'hC7;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;

  typedef enum logic [1:0] {
    KIND_PROG = 2'd0,
    KIND_SECT = 2'd1,
    KIND_BULK = 2'd2,
    KIND_STAT = 2'd3
  } reqKind_e;

  // which byte the datapath puts on the wire
  typedef enum logic [2:0] {
    TX_OPC  = 3'd0,
    TX_A2   = 3'd1,
    TX_A1   = 3'd2,
    TX_A0   = 3'd3,
    TX_DATA = 3'd4,
    TX_STAT = 3'd5,
    TX_ZERO = 3'd6
  } txSel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic       csActive;
    logic       startByte;
    txSel_e     txSel;
    logic [7:0] opcode;
    logic       latchReq;
    logic       advData;
    logic       gapStart;
  } strobe_t;

endpackage

// File: rtl/fws_datapath.sv
module fws_datapath
  import fws_pkg::*;
#(
  parameter int LEN_W    = 10,
  parameter int GAP_CLKS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          st,
  input  logic [23:0]      reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [7:0]       reqStatus,
  input  logic [7:0]       bufData,
  output logic [LEN_W-1:0] bufIdx,
  input  logic             miso,
  output logic             sck,
  output logic             csN,
  output logic             mosi,
  output logic             byteDone,
  output logic             rxLast,
  output logic             gapDone,
  output logic             lastByte,
  output logic             pageEnd,
  output logic             moreData
);

  localparam int GAP_W = $clog2(GAP_CLKS + 1);

  logic [23:0]      curAddr;
  logic [LEN_W-1:0] remain;
  logic [LEN_W-1:0] idx;
  logic [7:0]       statByte;
  logic [7:0]       txByte;
  logic [7:0]       sh;
  logic [2:0]       bitCnt;
  logic             phase;
  logic             busy;
  logic [GAP_W-1:0] gapCnt;

  // request / address tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      remain   <= '0;
      idx      <= '0;
      statByte <= '0;
    end else if (st.latchReq) begin
      curAddr  <= reqAddr;
      remain   <= reqLen;
      idx      <= '0;
      statByte <= reqStatus;
    end else if (st.advData) begin
      curAddr  <= curAddr + 24'd1;
      remain   <= remain - LEN_W'(1);
      idx      <= idx + LEN_W'(1);
    end
  end

  assign bufIdx   = idx;
  assign lastByte = (remain == LEN_W'(1));
  assign pageEnd  = (curAddr[7:0] == 8'hFF);
  assign moreData = (remain != '0);

  always_comb begin
    case (st.txSel)
      TX_OPC:  txByte = st.opcode;
      TX_A2:   txByte = curAddr[23:16];
      TX_A1:   txByte = curAddr[15:8];
      TX_A0:   txByte = curAddr[7:0];
      TX_DATA: txByte = bufData;
      TX_STAT: txByte = statByte;
      default: txByte = 8'h00;
    endcase
  end

  // byte shifter: two clocks per bit, sck high in the second
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sh       <= '0;
      bitCnt   <= '0;
      phase    <= 1'b0;
      busy     <= 1'b0;
      byteDone <= 1'b0;
      rxLast   <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (st.startByte) begin
        sh     <= txByte;
        bitCnt <= 3'd7;
        phase  <= 1'b0;
        busy   <= 1'b1;
      end else if (busy) begin
        if (!phase) begin
          phase  <= 1'b1;
          rxLast <= miso;
        end else begin
          phase <= 1'b0;
          sh    <= {sh[6:0], 1'b0};
          if (bitCnt == 3'd0) begin
            busy     <= 1'b0;
            byteDone <= 1'b1;
          end else begin
            bitCnt <= bitCnt - 3'd1;
          end
        end
      end
    end
  end

  assign sck  = busy & phase;
  assign mosi = sh[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) csN <= 1'b1;
    else       csN <= ~st.csActive;
  end

  // inter-frame gap timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                gapCnt <= '0;
    else if (st.gapStart)     gapCnt <= GAP_W'(GAP_CLKS - 1);
    else if (gapCnt != '0)    gapCnt <= gapCnt - GAP_W'(1);
  end

  assign gapDone = (gapCnt == '0);

endmodule

// File: rtl/fws_ctrl.sv
module fws_ctrl
  import fws_pkg::*;
#(
  parameter int MAX_POLLS = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  logic       reqLenZero,
  input  logic       byteDone,
  input  logic       rxLast,
  input  logic       gapDone,
  input  logic       lastByte,
  input  logic       pageEnd,
  input  logic       moreData,
  output strobe_t    st,
  output logic       reqReady,
  output logic       done,
  output logic       err
);

  localparam int POLL_W = $clog2(MAX_POLLS + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_WREN, S_WGAP, S_OPC, S_A2, S_A1, S_A0, S_DATA,
    S_STAT, S_CGAP, S_POLL, S_PREAD, S_PGAP, S_FIN
  } state_e;

  state_e            state;
  reqKind_e          kind;
  logic              armed;
  logic              wipLow;
  logic              errFlag;
  logic [POLL_W-1:0] pollCnt;

  function automatic logic [7:0] cmdOp(reqKind_e k);
    case (k)
      KIND_PROG: return OP_PP;
      KIND_SECT: return OP_SE;
      KIND_BULK: return OP_BE;
      default:   return OP_WRSR;
    endcase
  endfunction

  always_comb begin
    st        = '0;
    st.txSel  = TX_OPC;
    st.opcode = OP_WREN;
    case (state)
      S_IDLE:  st.latchReq = reqValid;
      S_WREN:  begin st.csActive = 1'b1; st.startByte = !armed; end
      S_OPC:   begin st.csActive = 1'b1; st.startByte = !armed; st.opcode = cmdOp(kind); end
      S_A2:    begin st.csActive = 1'b1; st.startByte = !armed; st.txSel = TX_A2; end
      S_A1:    begin st.csActive = 1'b1; st.startByte = !armed; st.txSel = TX_A1; end
      S_A0:    begin st.csActive = 1'b1; st.startByte = !armed; st.txSel = TX_A0; end
      S_DATA:  begin
        st.csActive = 1'b1; st.startByte = !armed; st.txSel = TX_DATA;
        st.advData  = byteDone;
      end
      S_STAT:  begin st.csActive = 1'b1; st.startByte = !armed; st.txSel = TX_STAT; end
      S_POLL:  begin st.csActive = 1'b1; st.startByte = !armed; st.opcode = OP_RDSR; end
      S_PREAD: begin st.csActive = 1'b1; st.startByte = !armed; st.txSel = TX_ZERO; end
      S_WGAP, S_CGAP, S_PGAP: st.gapStart = !armed;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      kind    <= KIND_PROG;
      armed   <= 1'b0;
      wipLow  <= 1'b0;
      errFlag <= 1'b0;
      pollCnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (reqValid) begin
          kind    <= reqKind_e'(reqKind);
          errFlag <= 1'b0;
          state   <= (reqKind_e'(reqKind) == KIND_PROG && reqLenZero) ? S_FIN : S_WREN;
        end
        S_WGAP, S_CGAP, S_PGAP: begin
          if (armed && gapDone) begin
            armed <= 1'b0;
            case (state)
              S_WGAP: state <= S_OPC;
              S_CGAP: begin state <= S_POLL; pollCnt <= '0; end
              default: begin
                if (wipLow)
                  state <= (kind == KIND_PROG && moreData) ? S_WREN : S_FIN;
                else if (pollCnt == POLL_W'(MAX_POLLS)) begin
                  errFlag <= 1'b1;
                  state   <= S_FIN;
                end else
                  state <= S_POLL;
              end
            endcase
          end else begin
            armed <= 1'b1;
          end
        end
        S_FIN: state <= S_IDLE;
        default: begin
          if (byteDone) begin
            armed <= 1'b0;
            case (state)
              S_WREN: state <= S_WGAP;
              S_OPC:  state <= (kind == KIND_BULK) ? S_CGAP :
                               (kind == KIND_STAT) ? S_STAT : S_A2;
              S_A2:   state <= S_A1;
              S_A1:   state <= S_A0;
              S_A0:   state <= (kind == KIND_PROG) ? S_DATA : S_CGAP;
              S_DATA: if (lastByte || pageEnd) state <= S_CGAP;
              S_STAT: state <= S_CGAP;
              S_POLL: state <= S_PREAD;
              default: begin
                wipLow  <= !rxLast;
                pollCnt <= pollCnt + POLL_W'(1);
                state   <= S_PGAP;
              end
            endcase
          end else begin
            armed <= 1'b1;
          end
        end
      endcase
    end
  end

  assign reqReady = (state == S_IDLE);
  assign done     = (state == S_FIN);
  assign err      = (state == S_FIN) && errFlag;

endmodule

// File: rtl/flash_wr_sequencer.sv
module flash_wr_sequencer
  import fws_pkg::*;
#(
  parameter int LEN_W     = 10,
  parameter int GAP_CLKS  = 4,
  parameter int MAX_POLLS = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqKind,
  input  logic [23:0]      reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [7:0]       reqStatus,
  output logic             reqReady,
  output logic [LEN_W-1:0] bufIdx,
  input  logic [7:0]       bufData,
  output logic             done,
  output logic             err,
  output logic             sck,
  output logic             csN,
  output logic             mosi,
  input  logic             miso
);

  strobe_t st;
  logic    byteDone, rxLast, gapDone, lastByte, pageEnd, moreData;

  fws_ctrl #(.MAX_POLLS(MAX_POLLS)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqKind(reqKind), .reqLenZero(reqLen == '0),
    .byteDone(byteDone), .rxLast(rxLast), .gapDone(gapDone),
    .lastByte(lastByte), .pageEnd(pageEnd), .moreData(moreData),
    .st(st), .reqReady(reqReady), .done(done), .err(err)
  );

  fws_datapath #(.LEN_W(LEN_W), .GAP_CLKS(GAP_CLKS)) dp_i (
    .clk(clk), .rstN(rstN), .st(st),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqStatus(reqStatus),
    .bufData(bufData), .bufIdx(bufIdx), .miso(miso),
    .sck(sck), .csN(csN), .mosi(mosi),
    .byteDone(byteDone), .rxLast(rxLast), .gapDone(gapDone),
    .lastByte(lastByte), .pageEnd(pageEnd), .moreData(moreData)
  );

endmodule

// File: rtl/flash_wr_sequencer_chk.sv
module flash_wr_sequencer_chk #(
  parameter int GAP_CLKS = 4
) (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sck,
  input logic mosi,
  input logic done,
  input logic err,
  input logic reqReady
);

  int hiCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       hiCnt <= GAP_CLKS;
    else if (!csN)                   hiCnt <= 0;
    else if (hiCnt < GAP_CLKS)       hiCnt <= hiCnt + 1;
  end

  p_sck_in_frame_r8: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> !csN);

  p_mosi_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> $stable(mosi));

  p_cs_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> (hiCnt >= GAP_CLKS));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_err_with_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done);

  p_not_ready_in_frame_r7: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> !reqReady);

endmodule

bind flash_wr_sequencer flash_wr_sequencer_chk #(.GAP_CLKS(GAP_CLKS)) chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi),
  .done(done), .err(err), .reqReady(reqReady)
);

// File: tb/flash_wr_sequencer_tb_top.sv
module flash_wr_sequencer_tb_top;

  localparam int LEN_W     = 10;
  localparam int GAP_CLKS  = 3;
  localparam int MAX_POLLS = 8;

  localparam logic [7:0] C_WREN = 8'h06, C_PP = 8'h02, C_SE = 8'hD8,
                         C_BE = 8'hC7, C_RDSR = 8'h05, C_WRSR = 8'h01;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqValid = 1'b0;
  logic [1:0]       reqKind = '0;
  logic [23:0]      reqAddr = '0;
  logic [LEN_W-1:0] reqLen = '0;
  logic [7:0]       reqStatus = '0;
  logic             reqReady, done, err, sck, csN, mosi;
  logic             miso = 1'b0;
  logic [LEN_W-1:0] bufIdx;
  logic [7:0]       bufData;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  assign bufData = pat(int'(bufIdx));

  flash_wr_sequencer #(.LEN_W(LEN_W), .GAP_CLKS(GAP_CLKS), .MAX_POLLS(MAX_POLLS)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqStatus(reqStatus),
    .reqReady(reqReady), .bufIdx(bufIdx), .bufData(bufData),
    .done(done), .err(err), .sck(sck), .csN(csN), .mosi(mosi), .miso(miso)
  );

  // ---------------- behavioural flash responder ----------------
  logic [7:0]  mem [0:2047];
  logic [7:0]  frameOp   [0:255];
  logic [23:0] frameAddr [0:255];
  int          frameData [0:255];
  int          frameCnt = 0, dataTotal = 0, wrenMiss = 0, pageViol = 0;
  int          busyLeft = 0, busyPolls = 0;
  int          byteNo = 0, bitNo = 0;
  logic        inFrame = 1'b0, wel = 1'b0;
  logic [7:0]  srReg = 8'h00, pendSr = 8'h00, curOp = 8'h00, shIn = 8'h00, stOut;
  logic [23:0] curAd = '0;

  initial for (int i = 0; i < 2048; i++) mem[i] = 8'hFF;

  always @(negedge csN) begin
    inFrame = 1'b1; byteNo = 0; bitNo = 0; curOp = 8'h00;
  end

  always @(posedge sck) if (!csN) begin
    shIn = {shIn[6:0], mosi};
    bitNo++;
    if (bitNo == 8) begin
      bitNo = 0;
      if (byteNo == 0) curOp = shIn;
      else if (byteNo <= 3) curAd = {curAd[15:0], shIn};
      else if (curOp == C_PP) begin
        if (byteNo - 4 >= 256 - int'(curAd[7:0])) pageViol++;
        mem[{curAd[10:8], 8'(int'(curAd[7:0]) + byteNo - 4)}] &= shIn;
        dataTotal++;
      end
      if (curOp == C_WRSR && byteNo == 1) pendSr = shIn;
      byteNo++;
    end
  end

  always @(negedge sck) if (!csN && curOp == C_RDSR && byteNo >= 1) begin
    stOut = {srReg[7:2], wel, (busyLeft != 0)};
    miso = stOut[7 - bitNo];
  end

  always @(posedge csN) if (inFrame) begin
    inFrame = 1'b0;
    if (frameCnt < 256) begin
      frameOp[frameCnt]   = curOp;
      frameAddr[frameCnt] = curAd;
      frameData[frameCnt] = (byteNo > 4) ? byteNo - 4 : 0;
    end
    frameCnt++;
    case (curOp)
      C_WREN: wel = (byteNo == 1);
      C_PP, C_SE, C_BE, C_WRSR: begin
        if (!wel) wrenMiss++;
        else begin
          busyLeft = busyPolls;
          if (curOp == C_SE || curOp == C_BE)
            for (int i = 0; i < 2048; i++) mem[i] = 8'hFF;
          if (curOp == C_WRSR) srReg = {pendSr[7:2], 2'b00};
        end
        wel = 1'b0;
      end
      C_RDSR: if (busyLeft > 0) busyLeft--;
      default: ;
    endcase
  end

  // minimum csN high time seen by the bench
  int hiRun = 1000, minGap = 1000;
  always @(negedge clk) if (rstN) begin
    if (csN) hiRun++;
    else begin
      if (hiRun > 0 && hiRun < minGap) minGap = hiRun;
      hiRun = 0;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic gotDone, gotErr;

  task automatic runReq(input logic [1:0] k, input logic [23:0] a,
                        input int len, input logic [7:0] s);
    @(negedge clk);
    reqValid = 1'b1; reqKind = k; reqAddr = a; reqLen = LEN_W'(len); reqStatus = s;
    @(negedge clk);
    reqValid = 1'b0;
    gotDone = 1'b0; gotErr = 1'b0;
    for (int c = 0; c < 40000 && !gotDone; c++) begin
      if (done) begin gotDone = 1'b1; gotErr = err; end
      else @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic [1:0]  kind;
    logic [23:0] addr;
    logic [15:0] len;
    logic [7:0]  stat;
    logic [7:0]  busy;
    logic [7:0]  frames;
    logic        expErr;
  } vec_t;

  // frames: 2 per write job (WREN + command) plus (busy+1) reads, per page
  localparam vec_t VECS [0:8] = '{
    '{2'd3, 24'h000000, 16'd0,   8'h1C, 8'd1, 8'd4,  1'b0},
    '{2'd1, 24'h000400, 16'd0,   8'h00, 8'd3, 8'd6,  1'b0},
    '{2'd1, 24'h000800, 16'd0,   8'h00, 8'd7, 8'd10, 1'b0},
    '{2'd1, 24'h000C00, 16'd0,   8'h00, 8'd8, 8'd10, 1'b1},
    '{2'd2, 24'h000000, 16'd0,   8'h00, 8'd0, 8'd3,  1'b0},
    '{2'd0, 24'h000000, 16'd256, 8'h00, 8'd0, 8'd3,  1'b0},
    '{2'd0, 24'h0001FD, 16'd6,   8'h00, 8'd2, 8'd10, 1'b0},
    '{2'd0, 24'h000280, 16'd300, 8'h00, 8'd1, 8'd8,  1'b0},
    '{2'd0, 24'h000410, 16'd16,  8'h00, 8'd1, 8'd4,  1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(csN == 1'b1,      "R11 csN",      int'(csN), 1);
    chk(sck == 1'b0,      "R11 sck",      int'(sck), 0);
    chk(done == 1'b0,     "R11 done",     int'(done), 0);
    chk(reqReady == 1'b1, "R11 reqReady", int'(reqReady), 1);

    for (int v = 0; v < 9; v++) begin
      automatic vec_t t = VECS[v];
      automatic int f0 = frameCnt, d0 = dataTotal, w0 = wrenMiss, p0 = pageViol;
      automatic int bad0 = 0, pp = 0, rd = 0;
      automatic int pagesExp;
      automatic logic [7:0] expOp;
      busyPolls = int'(t.busy);
      runReq(t.kind, t.addr, int'(t.len), t.stat);
      chk(gotDone == 1'b1, "R7 done seen", int'(gotDone), 1);
      chk(gotErr == t.expErr, "R6 err flag", int'(gotErr), int'(t.expErr));
      chk(frameCnt - f0 == int'(t.frames), "R5 frame count", frameCnt - f0, int'(t.frames));
      chk(wrenMiss == w0, "R1 write enable prefix", wrenMiss - w0, 0);
      chk(frameOp[f0] == C_WREN, "R1 first frame", int'(frameOp[f0]), int'(C_WREN));
      case (t.kind)
        2'd0: expOp = C_PP;
        2'd1: expOp = C_SE;
        2'd2: expOp = C_BE;
        default: expOp = C_WRSR;
      endcase
      chk(frameOp[f0 + 1] == expOp, "R4 command opcode", int'(frameOp[f0 + 1]), int'(expOp));
      for (int f = f0; f < frameCnt; f++) begin
        if (frameOp[f] == C_PP) pp++;
        if (frameOp[f] == C_RDSR) rd++;
      end
      if (t.kind == 2'd1)
        chk(frameAddr[f0 + 1] == t.addr, "R4 sector address", int'(frameAddr[f0 + 1]), int'(t.addr));
      if (t.kind == 2'd3)
        chk(srReg == {t.stat[7:2], 2'b00}, "R4 status byte", int'(srReg), int'(t.stat));
      if (t.kind == 2'd1 && t.expErr)
        chk(rd == MAX_POLLS, "R6 reads before timeout", rd, MAX_POLLS);
      if (t.kind == 2'd0) begin
        pagesExp = (int'(t.addr[7:0]) + int'(t.len) + 255) / 256;
        chk(pp == pagesExp, "R3 program frames", pp, pagesExp);
        chk(pageViol == p0, "R3 page limit", pageViol - p0, 0);
        chk(dataTotal - d0 == int'(t.len), "R3 byte total", dataTotal - d0, int'(t.len));
        chk(frameAddr[f0 + 1] == t.addr, "R2 first address", int'(frameAddr[f0 + 1]), int'(t.addr));
        for (int i = 0; i < int'(t.len); i++)
          if (mem[11'(int'(t.addr) + i)] !== pat(i)) bad0++;
        chk(bad0 == 0, "R2 programmed data", bad0, 0);
      end
    end

    // R10 zero-length program
    begin
      automatic int f0 = frameCnt;
      runReq(2'd0, 24'h000500, 0, 8'h00);
      chk(gotDone && !gotErr, "R10 zero length done", int'(gotErr), 0);
      repeat (10) @(negedge clk);
      chk(frameCnt == f0, "R10 no frames", frameCnt - f0, 0);
    end

    // R7 request while busy is dropped
    begin
      automatic int f0 = frameCnt;
      automatic int dn = 0;
      busyPolls = 2;
      @(negedge clk);
      reqValid = 1'b1; reqKind = 2'd2; reqAddr = '0; reqLen = '0;
      @(negedge clk);
      reqValid = 1'b0;
      repeat (20) @(negedge clk);
      chk(reqReady == 1'b0, "R7 not ready when busy", int'(reqReady), 0);
      reqValid = 1'b1; reqKind = 2'd1; reqAddr = 24'h000400;
      @(negedge clk);
      reqValid = 1'b0;
      for (int c = 0; c < 20000; c++) begin
        if (done) dn++;
        @(negedge clk);
      end
      chk(dn == 1, "R7 single completion", dn, 1);
      chk(frameCnt - f0 == 5, "R7 ignored request frames", frameCnt - f0, 5);
      chk(frameOp[f0 + 1] == C_BE, "R7 kept first job", int'(frameOp[f0 + 1]), int'(C_BE));
      chk(reqReady == 1'b1, "R7 ready after done", int'(reqReady), 1);
    end

    chk(minGap >= GAP_CLKS, "R9 chip select gap", minGap, GAP_CLKS);
    chk(sck == 1'b0 && csN == 1'b1, "R8 idle bus", int'(sck), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule